// File: doc/BRIEF.md
# Dual-Edge LFSR Pattern Generator

This block produces a 4-bit pseudo-random test pattern from a linear feedback shift register. The register moves on both the rising and the falling clock edge, so a full run through its sequence takes half as many clock periods as an ordinary single-edge register would. Each storage bit is a pair of level-sensitive latches. One latch is open while the clock is high and the other is open while the clock is low. A 2:1 multiplexer, with the clock as its select, passes whichever latch is currently closed to the output.

A start value is taken from the `seed` input when `load` is high at an edge. A zero seed would lock the register at zero, so the block replaces it with 0110. When `step` is high, each edge shifts the pattern one place toward the most significant bit. The new least significant bit is the XOR of bits 3 and 2. The block remembers the last start value it accepted. It raises `wrap` for one half-period when a step brings the pattern back to that value.

The pattern is a free-running level that is valid in every half-period, and it has no valid/ready handshake. The consumer cannot apply back-pressure. To pause the sequence it drops `step`, and the pattern then holds its value.

Top module: `dual_edge_lfsr`

## Requirements
- R1: While `rst_n` is low, the pattern, the stored start value and all latches take 0110 at once, with no clock edge needed, and `wrap` is 0. After release the pattern keeps 0110 until the first edge with `load` or `step` high.
- R2: When `load` is 1 before a clock edge of either polarity, the pattern after that edge equals `seed`. `load` has priority over `step`, and the loaded value becomes the new stored start value.
- R3: A `seed` of 0000 that is loaded is replaced by 0110.
- R4: When `step` is 1 and `load` is 0, an edge changes the pattern p to {p[2:0], p[3]^p[2]}, where bit 3 is the most significant bit.
- R5: The pattern is updated on rising edges as well as on falling edges, so it advances once per half clock period.
- R6: When `step` and `load` are both 0, the pattern stays unchanged, `wrap` stays 0, and changes on `seed` have no effect.
- R7: Starting from any nonzero value, 15 steps in a row visit 15 distinct nonzero patterns, and the 15th step returns to the starting value. The pattern is never 0000.
- R8: `wrap` is 1 for exactly the half-period that follows a stepping edge whose new pattern equals the stored start value. It is 0 in every other half-period, including the one right after a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges are active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Take `seed` as the new pattern and start value at the next edge |
| seed | input | 4 | Start value; zero is replaced by 0110 |
| step | input | 1 | Advance the pattern at each edge |
| pattern | output | 4 | Current test pattern |
| wrap | output | 1 | One-half-period pulse when the sequence returns to its start value |

## Verification
A change on `load`, `step` or `seed` shows on `pattern` and `wrap` after exactly one clock edge, which is half a period later, whichever edge polarity comes next. `rst_n` acts at once, with no edge. The bench changes its inputs in the middle of a half-period, waits a quarter-period past the next edge, and samples there. Every check therefore covers exactly one edge, and the samples alternate between the high and low clock phases. The wrap pulse is expected after the 15th step following a load, and it must be gone again on the 16th.

// File: rtl/dlfsr_pkg.sv
package dlfsr_pkg;
  localparam int unsigned PAT_W = 4;
  localparam logic [PAT_W-1:0] FALLBACK_SEED = 4'b0110;
  localparam int unsigned TAP_UPPER = 3;
  localparam int unsigned TAP_LOWER = 2;
endpackage

// File: rtl/dlfsr_de_cell.sv
// One storage bit built from two opposite-phase latches and a clock-selected mux.
module dlfsr_de_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_hi,
  output logic q_lo
);
  // open while clk is high, closes on the falling edge
  always_latch begin
    if (!rst_n)   q_hi = RST_VAL;
    else if (clk) q_hi = d;
  end

  // open while clk is low, closes on the rising edge
  always_latch begin
    if (!rst_n)    q_lo = RST_VAL;
    else if (!clk) q_lo = d;
  end

  // pass whichever latch is currently holding
  assign q = clk ? q_lo : q_hi;
endmodule

// File: rtl/dlfsr_de_reg.sv
module dlfsr_de_reg #(
  parameter int unsigned        W       = 4,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_hi,
  output logic [W-1:0] q_lo
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    dlfsr_de_cell #(.RST_VAL(RST_VAL[b])) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (d[b]),
      .q    (q[b]),
      .q_hi (q_hi[b]),
      .q_lo (q_lo[b])
    );
  end
endmodule

// File: rtl/dlfsr_next.sv
module dlfsr_next #(
  parameter int unsigned W      = 4,
  parameter int unsigned TAP_HI = 3,
  parameter int unsigned TAP_LO = 2
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  assign nxt = {cur[W-2:0], cur[TAP_HI] ^ cur[TAP_LO]};
endmodule

// File: rtl/dual_edge_lfsr.sv
module dual_edge_lfsr #(
  parameter int unsigned  W        = dlfsr_pkg::PAT_W,
  parameter int unsigned  TAP_HI   = dlfsr_pkg::TAP_UPPER,
  parameter int unsigned  TAP_LO   = dlfsr_pkg::TAP_LOWER,
  parameter logic [W-1:0] DEF_SEED = dlfsr_pkg::FALLBACK_SEED
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] pattern,
  output logic         wrap
);
  // one storage vector: {wrap flag, start value, pattern}
  localparam int unsigned SW = 2 * W + 1;
  localparam logic [SW-1:0] RST_ALL = {1'b0, DEF_SEED, DEF_SEED};

  logic [SW-1:0] d_all, q_all, hi_all, lo_all;
  logic [W-1:0]  start_q, adv, seed_eff, state_d, start_d;
  logic          wrap_d;

  assign pattern = q_all[W-1:0];
  assign start_q = q_all[2*W-1:W];
  assign wrap    = q_all[SW-1];

  dlfsr_next #(.W(W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_next (
    .cur(pattern),
    .nxt(adv)
  );

  always_comb begin
    seed_eff = (seed == '0) ? DEF_SEED : seed;
    if (load)      state_d = seed_eff;
    else if (step) state_d = adv;
    else           state_d = pattern;
    start_d = load ? seed_eff : start_q;
    wrap_d  = step & ~load & (adv == start_q);
  end

  assign d_all = {wrap_d, start_d, state_d};

  dlfsr_de_reg #(.W(SW), .RST_VAL(RST_ALL)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (d_all),
    .q    (q_all),
    .q_hi (hi_all),
    .q_lo (lo_all)
  );
endmodule

// File: rtl/dual_edge_lfsr_chk.sv
// Just before a rising edge the high latch holds the pattern and the low latch
// holds the value about to be shown; just before a falling edge the roles swap.
module dual_edge_lfsr_chk #(
  parameter int unsigned  W        = 4,
  parameter int unsigned  TAP_HI   = 3,
  parameter int unsigned  TAP_LO   = 2,
  parameter logic [W-1:0] DEF_SEED = 4'b0110
) (
  input logic           clk,
  input logic           rst_n,
  input logic           load,
  input logic [W-1:0]   seed,
  input logic           step,
  input logic [W-1:0]   pattern,
  input logic           wrap,
  input logic [2*W:0]   hi_all,
  input logic [2*W:0]   lo_all
);
  function automatic logic [W-1:0] shift_fb(input logic [W-1:0] v);
    return {v[W-2:0], v[TAP_HI] ^ v[TAP_LO]};
  endfunction

  logic [W-1:0] hi_st, lo_st, hi_start, lo_start;
  assign hi_st    = hi_all[W-1:0];
  assign lo_st    = lo_all[W-1:0];
  assign hi_start = hi_all[2*W-1:W];
  assign lo_start = lo_all[2*W-1:W];

  // R1
  reset_value_chk: assert property (@(posedge clk) !rst_n |-> (pattern == DEF_SEED && !wrap));

  // R2
  load_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (lo_st == ((seed == '0) ? DEF_SEED : seed) && lo_start == lo_st));
  // R2
  load_fall_chk: assert property (@(negedge clk) disable iff (!rst_n)
    load |-> (hi_st == ((seed == '0) ? DEF_SEED : seed) && hi_start == hi_st));

  // R4
  step_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> lo_st == shift_fb(hi_st));
  // R4
  step_fall_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (step && !load) |-> hi_st == shift_fb(lo_st));

  // R6
  hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |-> (lo_st == hi_st && !lo_all[2*W]));
  // R6
  hold_fall_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (!step && !load) |-> (hi_st == lo_st && !hi_all[2*W]));

  // R7
  nonzero_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) pattern != '0);
  // R7
  nonzero_fall_chk: assert property (@(negedge clk) disable iff (!rst_n) pattern != '0);

  // R8
  wrap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) wrap |-> pattern == hi_start);
  // R8
  wrap_fall_chk: assert property (@(negedge clk) disable iff (!rst_n) wrap |-> pattern == lo_start);
endmodule

bind dual_edge_lfsr dual_edge_lfsr_chk #(
  .W(W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .DEF_SEED(DEF_SEED)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load   (load),
  .seed   (seed),
  .step   (step),
  .pattern(pattern),
  .wrap   (wrap),
  .hi_all (hi_all),
  .lo_all (lo_all)
);

// File: tb/dual_edge_lfsr_test.sv
`timescale 1ns/1ps
module dual_edge_lfsr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic       step = 1'b0;
  logic [3:0] seed = 4'd0;
  logic [3:0] pattern;
  logic       wrap;

  int total = 0;
  int bad = 0;
  logic ended = 1'b0;

  dual_edge_lfsr uut (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(seed),
    .step(step), .pattern(pattern), .wrap(wrap)
  );

  // 125 MHz: 8 ns period, an edge every 4 ns
  always #4 clk = ~clk;

  function automatic logic [3:0] nx(input logic [3:0] p);
    return {p[2:0], p[3] ^ p[2]};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // inputs are driven mid-half-period; this passes exactly one edge
  task automatic tick();
    #4;
  endtask

  // load s, then step 15 times: visit, uniqueness, both edges, wrap
  task automatic run_cycle(input logic [3:0] s, input logic with_step);
    logic [3:0] exp, prev;
    logic [15:0] seen;
    logic prev_lvl;
    exp = (s == 4'd0) ? 4'b0110 : s;
    seed = s; load = 1'b1; step = with_step;
    tick();
    chk(pattern, exp, "R2 load value");
    chk(wrap, 0, "R8 no wrap after load");
    load = 1'b0; step = 1'b1;
    seen = 16'h0;
    seen[exp] = 1'b1;
    prev = pattern;
    prev_lvl = clk;
    for (int i = 1; i <= 15; i++) begin
      tick();
      exp = nx(exp);
      chk(pattern, exp, "R4 step value");
      chk(clk != prev_lvl && pattern != prev, 1, "R5 advance on alternating edge");
      chk(pattern != 4'd0, 1, "R7 nonzero");
      if (i < 15) chk(seen[pattern], 0, "R7 distinct");
      else        chk(pattern, (s == 4'd0) ? 4'b0110 : s, "R7 return to start");
      seen[pattern] = 1'b1;
      chk(wrap, (i == 15), "R8 wrap timing");
      prev = pattern;
      prev_lvl = clk;
    end
    tick();
    chk(pattern, nx(exp), "R4 step past wrap");
    chk(wrap, 0, "R8 wrap lasts one half-period");
  endtask

  initial begin
    #2;
    chk(pattern, 4'b0110, "R1 reset pattern");
    chk(wrap, 0, "R1 reset wrap");
    rst_n = 1'b1;
    tick();
    chk(pattern, 4'b0110, "R1 idle after release");

    run_cycle(4'b0110, 1'b0);
    run_cycle(4'b1001, 1'b1);       // R2 load beats step
    run_cycle(4'b0000, 1'b0);       // R3 zero seed substituted
    chk(pattern, 4'b1101, "R3 sequence from substituted seed");
    run_cycle(4'b1000, 1'b0);

    // R6 hold: seed changes ignored, pattern and wrap steady
    begin
      logic [3:0] held;
      step = 1'b0;
      tick();
      held = pattern;
      for (int k = 0; k < 4; k++) begin
        seed = 4'(k * 5 + 3);
        tick();
        chk(pattern, held, "R6 hold pattern");
        chk(wrap, 0, "R6 hold wrap");
      end
    end

    // R1 asynchronous reset mid-half-period, then start value is default
    step = 1'b1;
    tick();
    step = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(pattern, 4'b0110, "R1 async reset immediate");
    chk(wrap, 0, "R1 async reset wrap");
    rst_n = 1'b1;
    #3;
    chk(pattern, 4'b0110, "R1 hold after release");
    step = 1'b1;
    for (int i = 1; i <= 15; i++) begin
      tick();
      chk(wrap, (i == 15), "R8 wrap to default start after reset");
    end
    step = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    ended = 1'b1;
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule